// File: doc/BRIEF.md
# Inset Picture Border and Background Compositor

This block picks the colour of every pixel of an inset picture window on its way to the output. Each pixel arrives with its position inside the window, a flag saying whether the memory holds live picture content at that spot, and the live YUV value. The block decides whether the pixel belongs to the outer border, to the thin grid lines between sub-pictures, to a blanked sub-picture, to live content (optionally highlighted) or to empty background. It then emits the matching YUV triple.

The window is a single picture or a grid of up to `MAX_COLS` x `MAX_ROWS` equal sub-pictures. The outer border has separately programmed horizontal and vertical widths. Border colours carry 4 significant bits per component and background colours carry 2. The unused low bits are filled with zeros, and U and V are offset-binary around 128. One sub-picture is "selected" by index. It can be blanked to the background colour, or its live luma can be brightened so that it stands out.

Pixels move through a valid/ready stream with one register stage. A pixel is taken in any cycle where `in_valid` and `in_ready` are both high. The result is offered on the output in the next cycle and held unchanged while `out_ready` is low. Back-pressure passes straight through: `in_ready` drops only while a result is waiting and `out_ready` is low. Configuration inputs are plain levels, sampled in the cycle in which a pixel is accepted.

Top module: `inset_overlay`

## Requirements
- R1: `in_ready` equals (not `out_valid`) or `out_ready`. A pixel accepted at a clock edge is on `out_y/out_u/out_v` with `out_valid` high after that edge, and it stays unchanged while `out_ready` is low. Without an accepted pixel, a consumed result leaves `out_valid` low.
- R2: A pixel with x < `cfg_fw_h`, x >= `cfg_win_w`-`cfg_fw_h`, y < `cfg_fw_v` or y >= `cfg_win_h`-`cfg_fw_v` takes the border colour. Each component is its 4-bit field in bits 7:4, with bits 3:0 zero. A width of 0 gives no border on that axis.
- R3: In grid mode (`cfg_multi`=1) with `cfg_inner_on`=1, take interior coordinates xi = x-`cfg_fw_h` and yi = y-`cfg_fw_v`. A pixel with xi in [k*`cfg_cell_w`, k*`cfg_cell_w`+4) for 1 <= k < `cfg_cols`, or with yi in [k*`cfg_cell_h`, k*`cfg_cell_h`+2) for 1 <= k < `cfg_rows`, takes the border colour. There are no grid lines in single mode. Cells must be at least 4 pixels wide and 2 lines high.
- R4: The column is min(xi / `cfg_cell_w`, `cfg_cols`-1) and the row is min(yi / `cfg_cell_h`, `cfg_rows`-1). The sub-picture index is row*`cfg_cols`+col, and it is always 0 in single mode. A pixel is "selected" when its index equals `cfg_sel_idx`.
- R5: A non-border pixel with `in_pic_act`=1 in the selected sub-picture, with `cfg_blank`=1, takes the programmed background colour. Blanking wins over highlighting; both border kinds win over blanking.
- R6: With `cfg_hilite`=1 and no blanking, a live pixel in the selected sub-picture outputs Y+`HL_GAIN` (64 by default), saturating at 255. U and V pass through unchanged.
- R7: Any other non-border pixel with `in_pic_act`=1 passes its live Y, U and V through unchanged.
- R8: A non-border pixel with `in_pic_act`=0 takes a background value. In single mode it is the programmed background colour: each component is its 2-bit field in bits 7:6, with bits 5:0 zero. In grid mode it is black (Y=0, U=128, V=128) when `cfg_mbg_sel`=0, and the programmed background colour when `cfg_mbg_sel`=1.
- R9: While reset is active and right after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_x | input | CRD_W | Pixel column inside the window, border included |
| in_y | input | CRD_W | Line inside the window, border included |
| in_pic_act | input | 1 | Live picture content present at this pixel |
| in_live_y | input | 8 | Live luma |
| in_live_u | input | 8 | Live U, offset-binary |
| in_live_v | input | 8 | Live V, offset-binary |
| cfg_win_w | input | CRD_W | Window width in pixels, border included |
| cfg_win_h | input | CRD_W | Window height in lines, border included |
| cfg_fw_h | input | CRD_W | Left/right border width in pixels |
| cfg_fw_v | input | CRD_W | Top/bottom border height in lines |
| cfg_multi | input | 1 | 1 = grid of sub-pictures |
| cfg_cols | input | COL_W | Grid columns, 1..MAX_COLS |
| cfg_rows | input | ROW_W | Grid rows, 1..MAX_ROWS |
| cfg_cell_w | input | CRD_W | Sub-picture width in pixels |
| cfg_cell_h | input | CRD_W | Sub-picture height in lines |
| cfg_inner_on | input | 1 | Enable grid lines between sub-pictures |
| cfg_frm_y | input | FRC_W | Border luma high bits |
| cfg_frm_u | input | FRC_W | Border U high bits |
| cfg_frm_v | input | FRC_W | Border V high bits |
| cfg_bg_y | input | BGC_W | Background luma high bits |
| cfg_bg_u | input | BGC_W | Background U high bits |
| cfg_bg_v | input | BGC_W | Background V high bits |
| cfg_mbg_sel | input | 1 | Grid-mode empty area: 0 black, 1 background colour |
| cfg_sel_idx | input | SUB_W | Index of the selected sub-picture |
| cfg_blank | input | 1 | Blank the selected sub-picture |
| cfg_hilite | input | 1 | Highlight the selected sub-picture |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_y | output | 8 | Output luma |
| out_u | output | 8 | Output U |
| out_v | output | 8 | Output V |

## Verification
Two pairs of rules can apply to the same pixel.

- **Blanking and highlighting.** One configuration selects the same sub-picture for both, so every live pixel of that cell must come out in the background colour and never brightened.
- **Grid lines and blanking or highlighting.** Grid lines fall on the leading edge of each cell, and the selected cell's own lines must keep the border colour.

The bench sweeps every coordinate of each small window under random output stalls and input gaps. It compares each emitted pixel with a value computed by division and modulo from the rules above.

// File: rtl/inset_ovl_pkg.sv
package inset_ovl_pkg;
  parameter int unsigned PIX_W = 8;

  typedef struct packed {
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] v;
  } yuv_t;

  typedef enum logic [1:0] {
    SRC_FRAME = 2'd0,
    SRC_BLANK = 2'd1,
    SRC_LIVE  = 2'd2,
    SRC_BACK  = 2'd3
  } src_e;
endpackage

// File: rtl/inset_ovl_axis.sv
// Classifies one coordinate axis: outer border, grid strip, cell index.
module inset_ovl_axis #(
  parameter int unsigned CRD_W     = 10,
  parameter int unsigned MAX_CELLS = 4,
  parameter int unsigned STRIP     = 4,
  localparam int unsigned CNT_W    = $clog2(MAX_CELLS + 1),
  localparam int unsigned IDX_W    = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1
) (
  input  logic [CRD_W-1:0] pos,
  input  logic [CRD_W-1:0] win_len,
  input  logic [CRD_W-1:0] border,
  input  logic [CRD_W-1:0] cell_len,
  input  logic [CNT_W-1:0] cells,
  input  logic             grid_en,
  output logic             on_border,
  output logic             on_strip,
  output logic [IDX_W-1:0] cell_idx
);
  localparam int unsigned EW = CRD_W + IDX_W;

  logic [CRD_W-1:0]     far_edge;
  logic [CRD_W-1:0]     inner;
  logic [EW-1:0]        inner_x;
  logic [MAX_CELLS-1:0] past_edge;
  logic [MAX_CELLS-1:0] in_band;

  assign far_edge  = win_len - border;
  assign on_border = (pos < border) || (pos >= far_edge);
  assign inner     = pos - border;
  assign inner_x   = EW'(inner);

  assign past_edge[0] = 1'b0;
  assign in_band[0]   = 1'b0;

  for (genvar k = 1; k < MAX_CELLS; k++) begin : g_edge
    logic [EW-1:0] edge_at;
    logic          edge_live;
    assign edge_at      = EW'(cell_len) * EW'(k);
    assign edge_live    = grid_en && (CNT_W'(k) < cells);
    assign past_edge[k] = edge_live && (inner_x >= edge_at);
    assign in_band[k]   = past_edge[k] && (inner_x < edge_at + EW'(STRIP));
  end

  // Edges passed are monotonic in k, so their count is the cell index.
  assign cell_idx = IDX_W'($countones(past_edge));
  assign on_strip = |in_band;
endmodule

// File: rtl/inset_ovl_pick.sv
// Priority colour selection: border, blank, live (with highlight), background.
module inset_ovl_pick
  import inset_ovl_pkg::*;
#(
  parameter int unsigned FRC_W   = 4,
  parameter int unsigned BGC_W   = 2,
  parameter int unsigned HL_GAIN = 64
) (
  input  logic             on_frame,
  input  logic             pic_act,
  input  logic             is_sel,
  input  logic             blank_en,
  input  logic             hilite_en,
  input  logic             multi,
  input  logic             mbg_sel,
  input  yuv_t             live,
  input  logic [FRC_W-1:0] frm_y,
  input  logic [FRC_W-1:0] frm_u,
  input  logic [FRC_W-1:0] frm_v,
  input  logic [BGC_W-1:0] bg_y,
  input  logic [BGC_W-1:0] bg_u,
  input  logic [BGC_W-1:0] bg_v,
  output yuv_t             pix
);
  localparam int unsigned FPAD = PIX_W - FRC_W;
  localparam int unsigned BPAD = PIX_W - BGC_W;
  localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

  yuv_t            frame_c, back_c, black_c, bright_c;
  logic [PIX_W:0]  y_sum;
  src_e            src;

  assign frame_c = '{y: {frm_y, {FPAD{1'b0}}}, u: {frm_u, {FPAD{1'b0}}},
                     v: {frm_v, {FPAD{1'b0}}}};
  assign back_c  = '{y: {bg_y, {BPAD{1'b0}}}, u: {bg_u, {BPAD{1'b0}}},
                     v: {bg_v, {BPAD{1'b0}}}};
  assign black_c = '{y: '0, u: MID, v: MID};

  assign y_sum    = {1'b0, live.y} + (PIX_W + 1)'(HL_GAIN);
  assign bright_c = '{y: y_sum[PIX_W] ? {PIX_W{1'b1}} : y_sum[PIX_W-1:0],
                      u: live.u, v: live.v};

  always_comb begin
    if (on_frame)                          src = SRC_FRAME;
    else if (pic_act && is_sel && blank_en) src = SRC_BLANK;
    else if (pic_act)                      src = SRC_LIVE;
    else                                   src = SRC_BACK;
  end

  always_comb begin
    unique case (src)
      SRC_FRAME: pix = frame_c;
      SRC_BLANK: pix = back_c;
      SRC_LIVE:  pix = (hilite_en && is_sel) ? bright_c : live;
      default:   pix = (multi && !mbg_sel) ? black_c : back_c;
    endcase
  end
endmodule

// File: rtl/inset_ovl_stage.sv
// One-deep valid/ready output register.
module inset_ovl_stage
  import inset_ovl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  yuv_t in_pix,
  output logic out_valid,
  input  logic out_ready,
  output yuv_t out_pix
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= in_pix;
    end
  end
endmodule

// File: rtl/inset_overlay.sv
module inset_overlay
  import inset_ovl_pkg::*;
#(
  parameter int unsigned CRD_W    = 10,
  parameter int unsigned MAX_COLS = 4,
  parameter int unsigned MAX_ROWS = 4,
  parameter int unsigned FRC_W    = 4,
  parameter int unsigned BGC_W    = 2,
  parameter int unsigned INNER_W  = 4,
  parameter int unsigned INNER_H  = 2,
  parameter int unsigned HL_GAIN  = 64,
  localparam int unsigned COL_W   = $clog2(MAX_COLS + 1),
  localparam int unsigned ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int unsigned SUB_W   = (MAX_COLS * MAX_ROWS > 1) ? $clog2(MAX_COLS * MAX_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CRD_W-1:0] in_x,
  input  logic [CRD_W-1:0] in_y,
  input  logic             in_pic_act,
  input  logic [PIX_W-1:0] in_live_y,
  input  logic [PIX_W-1:0] in_live_u,
  input  logic [PIX_W-1:0] in_live_v,
  input  logic [CRD_W-1:0] cfg_win_w,
  input  logic [CRD_W-1:0] cfg_win_h,
  input  logic [CRD_W-1:0] cfg_fw_h,
  input  logic [CRD_W-1:0] cfg_fw_v,
  input  logic             cfg_multi,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [CRD_W-1:0] cfg_cell_w,
  input  logic [CRD_W-1:0] cfg_cell_h,
  input  logic             cfg_inner_on,
  input  logic [FRC_W-1:0] cfg_frm_y,
  input  logic [FRC_W-1:0] cfg_frm_u,
  input  logic [FRC_W-1:0] cfg_frm_v,
  input  logic [BGC_W-1:0] cfg_bg_y,
  input  logic [BGC_W-1:0] cfg_bg_u,
  input  logic [BGC_W-1:0] cfg_bg_v,
  input  logic             cfg_mbg_sel,
  input  logic [SUB_W-1:0] cfg_sel_idx,
  input  logic             cfg_blank,
  input  logic             cfg_hilite,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_u,
  output logic [PIX_W-1:0] out_v
);
  localparam int unsigned CIX_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
  localparam int unsigned RIX_W = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1;

  logic             bord_x, bord_y, strip_x, strip_y;
  logic [CIX_W-1:0] col_idx;
  logic [RIX_W-1:0] row_idx;
  logic [SUB_W-1:0] sub_idx;
  logic             on_frame, is_sel;
  yuv_t             live_pix, pick_pix, reg_pix;

  inset_ovl_axis #(.CRD_W(CRD_W), .MAX_CELLS(MAX_COLS), .STRIP(INNER_W)) u_axis_x (
    .pos(in_x), .win_len(cfg_win_w), .border(cfg_fw_h), .cell_len(cfg_cell_w),
    .cells(cfg_cols), .grid_en(cfg_multi),
    .on_border(bord_x), .on_strip(strip_x), .cell_idx(col_idx)
  );

  inset_ovl_axis #(.CRD_W(CRD_W), .MAX_CELLS(MAX_ROWS), .STRIP(INNER_H)) u_axis_y (
    .pos(in_y), .win_len(cfg_win_h), .border(cfg_fw_v), .cell_len(cfg_cell_h),
    .cells(cfg_rows), .grid_en(cfg_multi),
    .on_border(bord_y), .on_strip(strip_y), .cell_idx(row_idx)
  );

  assign sub_idx  = SUB_W'(row_idx) * SUB_W'(cfg_cols) + SUB_W'(col_idx);
  assign is_sel   = (sub_idx == cfg_sel_idx);
  assign on_frame = bord_x || bord_y ||
                    (cfg_multi && cfg_inner_on && (strip_x || strip_y));
  assign live_pix = '{y: in_live_y, u: in_live_u, v: in_live_v};

  inset_ovl_pick #(.FRC_W(FRC_W), .BGC_W(BGC_W), .HL_GAIN(HL_GAIN)) u_pick (
    .on_frame(on_frame), .pic_act(in_pic_act), .is_sel(is_sel),
    .blank_en(cfg_blank), .hilite_en(cfg_hilite), .multi(cfg_multi),
    .mbg_sel(cfg_mbg_sel), .live(live_pix),
    .frm_y(cfg_frm_y), .frm_u(cfg_frm_u), .frm_v(cfg_frm_v),
    .bg_y(cfg_bg_y), .bg_u(cfg_bg_u), .bg_v(cfg_bg_v),
    .pix(pick_pix)
  );

  inset_ovl_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(pick_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(reg_pix)
  );

  assign out_y = reg_pix.y;
  assign out_u = reg_pix.u;
  assign out_v = reg_pix.v;
endmodule

// File: rtl/inset_ovl_chk.sv
module inset_ovl_chk
  import inset_ovl_pkg::*;
#(
  parameter int unsigned CRD_W = 10,
  parameter int unsigned FRC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CRD_W-1:0] in_x,
  input logic [CRD_W-1:0] cfg_fw_h,
  input logic [FRC_W-1:0] cfg_frm_y,
  input logic [FRC_W-1:0] cfg_frm_u,
  input logic [FRC_W-1:0] cfg_frm_v,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_y,
  input logic [PIX_W-1:0] out_u,
  input logic [PIX_W-1:0] out_v
);
  localparam int unsigned FPAD = PIX_W - FRC_W;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_u) && $stable(out_v));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_left_border_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_x < cfg_fw_h) |=>
      out_y == {$past(cfg_frm_y), {FPAD{1'b0}}} &&
      out_u == {$past(cfg_frm_u), {FPAD{1'b0}}} &&
      out_v == {$past(cfg_frm_v), {FPAD{1'b0}}});
endmodule

bind inset_overlay inset_ovl_chk #(.CRD_W(CRD_W), .FRC_W(FRC_W)) u_chk (.*);

// File: tb/inset_overlay_test.sv
`timescale 1ns/1ps
module inset_overlay_test;
  localparam int CRD_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             in_valid = 1'b0, in_ready, in_pic_act = 1'b0;
  logic [CRD_W-1:0] in_x = '0, in_y = '0;
  logic [7:0]       in_live_y = '0, in_live_u = '0, in_live_v = '0;
  logic [CRD_W-1:0] cfg_win_w = '0, cfg_win_h = '0, cfg_fw_h = '0, cfg_fw_v = '0;
  logic [CRD_W-1:0] cfg_cell_w = '0, cfg_cell_h = '0;
  logic             cfg_multi = 1'b0, cfg_inner_on = 1'b0, cfg_mbg_sel = 1'b0;
  logic             cfg_blank = 1'b0, cfg_hilite = 1'b0;
  logic [2:0]       cfg_cols = 3'd1, cfg_rows = 3'd1;
  logic [3:0]       cfg_frm_y = '0, cfg_frm_u = '0, cfg_frm_v = '0, cfg_sel_idx = '0;
  logic [1:0]       cfg_bg_y = '0, cfg_bg_u = '0, cfg_bg_v = '0;
  logic             out_valid, out_ready = 1'b0;
  logic [7:0]       out_y, out_u, out_v;

  inset_overlay uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  // configuration mirror used by the model
  int w, h, fh, fv, cw, ch, cols, rows, sel, fy, fu, fvv, by, bu, bv;
  bit multi, inner, mbg, blank, hil;

  int q_y[$], q_u[$], q_v[$], q_x[$], q_yy[$];
  string q_tag[$];

  task automatic check(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic void model(input int x, input int y, input bit act,
                                input int ly, input int lu, input int lv,
                                output int ey, output int eu, output int ev,
                                output string tag);
    int xi, yi, col, row, idx;
    bit sel_hit;
    if (x < fh || x >= w - fh || y < fv || y >= h - fv) begin
      ey = fy * 16; eu = fu * 16; ev = fvv * 16; tag = "R2"; return;
    end
    xi = x - fh; yi = y - fv; col = 0; row = 0;
    if (multi) begin
      col = xi / cw; if (col > cols - 1) col = cols - 1;
      row = yi / ch; if (row > rows - 1) row = rows - 1;
      if (inner && ((col > 0 && xi - col * cw < 4) || (row > 0 && yi - row * ch < 2))) begin
        ey = fy * 16; eu = fu * 16; ev = fvv * 16; tag = "R3"; return;
      end
    end
    idx = row * cols + col;
    sel_hit = (idx == sel);
    if (act && blank && sel_hit) begin
      ey = by * 64; eu = bu * 64; ev = bv * 64; tag = "R4,R5";
    end else if (act && hil && sel_hit) begin
      ey = (ly + 64 > 255) ? 255 : ly + 64; eu = lu; ev = lv; tag = "R4,R6";
    end else if (act) begin
      ey = ly; eu = lu; ev = lv; tag = "R7";
    end else if (multi && !mbg) begin
      ey = 0; eu = 128; ev = 128; tag = "R8";
    end else begin
      ey = by * 64; eu = bu * 64; ev = bv * 64; tag = "R8";
    end
  endfunction

  task automatic apply_cfg();
    cfg_win_w = CRD_W'(w); cfg_win_h = CRD_W'(h); cfg_fw_h = CRD_W'(fh); cfg_fw_v = CRD_W'(fv);
    cfg_cell_w = CRD_W'(cw); cfg_cell_h = CRD_W'(ch);
    cfg_cols = 3'(cols); cfg_rows = 3'(rows); cfg_sel_idx = 4'(sel);
    cfg_multi = multi; cfg_inner_on = inner; cfg_mbg_sel = mbg;
    cfg_blank = blank; cfg_hilite = hil;
    cfg_frm_y = 4'(fy); cfg_frm_u = 4'(fu); cfg_frm_v = 4'(fvv);
    cfg_bg_y = 2'(by); cfg_bg_u = 2'(bu); cfg_bg_v = 2'(bv);
  endtask

  task automatic sweep(input int salt);
    int nx = 0, ny = 0, got = 0, total;
    bit sending = 1'b1;
    total = w * h;
    apply_cfg();
    while (got < total) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[1:0] != 2'b00);
      in_valid  = sending && (lfsr[4:2] != 3'b000);
      in_x = CRD_W'(nx); in_y = CRD_W'(ny);
      in_pic_act = ((nx + 2 * ny + salt) % 7) != 3;
      in_live_y = 8'((nx * 37 + ny * 11 + salt * 5) & 255);
      in_live_u = 8'((nx * 5 + ny * 3) & 255);
      in_live_v = 8'((255 - nx * 9) & 255);
      #1;
      if (out_valid && out_ready) begin
        string t;
        t = $sformatf("%s px(%0d,%0d)", q_tag[0], q_x[0], q_yy[0]);
        check(q_tag[0], int'(out_y), q_y[0], {t, " Y"});
        check(q_tag[0], int'(out_u), q_u[0], {t, " U"});
        check(q_tag[0], int'(out_v), q_v[0], {t, " V"});
        void'(q_y.pop_front()); void'(q_u.pop_front()); void'(q_v.pop_front());
        void'(q_x.pop_front()); void'(q_yy.pop_front()); void'(q_tag.pop_front());
        got++;
      end
      if (in_valid && in_ready) begin
        int ey, eu, ev;
        string tg;
        model(nx, ny, in_pic_act, int'(in_live_y), int'(in_live_u), int'(in_live_v),
              ey, eu, ev, tg);
        q_y.push_back(ey); q_u.push_back(eu); q_v.push_back(ev);
        q_x.push_back(nx); q_yy.push_back(ny); q_tag.push_back(tg);
        nx++;
        if (nx == w) begin nx = 0; ny++; end
        if (ny == h) sending = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0, "drained valid");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R9", int'(out_valid), 0, "out_valid in reset");
    check("R9", int'(in_ready), 1, "in_ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(out_valid), 0, "out_valid after reset");
    check("R9", int'(in_ready), 1, "in_ready after reset");

    // single picture, highlight of index 0, border both axes
    w = 20; h = 12; fh = 3; fv = 2; cw = 6; ch = 4; cols = 1; rows = 1; sel = 0;
    multi = 0; inner = 0; mbg = 0; blank = 0; hil = 1;
    fy = 9; fu = 3; fvv = 12; by = 2; bu = 1; bv = 3;
    sweep(0);

    // grid 3x2 with grid lines, black empty areas, highlight cell 4
    w = 22; h = 12; fh = 2; fv = 1; cw = 6; ch = 5; cols = 3; rows = 2; sel = 4;
    multi = 1; inner = 1; mbg = 0; blank = 0; hil = 1;
    fy = 15; fu = 0; fvv = 7; by = 3; bu = 2; bv = 0;
    sweep(1);

    // same grid, no lines, blank and highlight on cell 1 together
    inner = 0; mbg = 1; blank = 1; hil = 1; sel = 1;
    fy = 4; fu = 10; fvv = 1; by = 1; bu = 3; bv = 2;
    sweep(2);

    // grid 4x4, zero-width border, lines, highlight last cell
    w = 20; h = 12; fh = 0; fv = 0; cw = 5; ch = 3; cols = 4; rows = 4; sel = 15;
    multi = 1; inner = 1; mbg = 1; blank = 0; hil = 1;
    fy = 6; fu = 14; fvv = 2; by = 0; bu = 1; bv = 1;
    sweep(3);

    // single picture fully blanked, thin border
    w = 10; h = 8; fh = 1; fv = 1; cw = 4; ch = 2; cols = 1; rows = 1; sel = 0;
    multi = 0; inner = 1; mbg = 0; blank = 1; hil = 0;
    fy = 1; fu = 8; fvv = 5; by = 3; bu = 0; bv = 2;
    sweep(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule